// File: doc/BRIEF.md
# Bipolar Return-to-Zero Serial Word Transmitter

This block is the transmit half of an avionics serial link. A host writes words into it in two 16-bit halves. The words wait in a small FIFO. When the host allows sending, the block adds a parity bit and sends each word least significant bit first on a bipolar return-to-zero line.

The line is two drive bits, `line_hi` and `line_lo`, and at most one of them is high at a time. Each bit cell has a driven part followed by a null part in which both drive bits are low. Consecutive words are separated by a null gap. A control word loaded on a dedicated strobe selects odd or even parity and a word length of 32 or 25 bits. A ready flag tells the host whether the FIFO has room for another word.

Top module: `bprz_tx`

## Requirements
- R1: A pulse on `ld_lo` stores `din` as bits 15..0 of the pending word. A later pulse on `ld_hi` supplies bits 31..16 and commits the whole 32-bit word to the FIFO. Each strobe is a one-cycle pulse, and each cycle it is high counts as one load.
- R2: The FIFO holds `DEPTH` words (default 8). `tx_ready` is high while fewer than `DEPTH` words are stored. A `ld_hi` pulse that arrives while the FIFO is full is ignored and never reaches the line.
- R3: While `send_en` is low, no word is started. While it is high, stored words are sent in the order they were written.
- R4: Bits leave least significant first. A 1 bit drives `line_hi` and a 0 bit drives `line_lo`. The two drive bits are never high together.
- R5: Control bit 0 selects the parity. With 0 the total number of ones in the sent bits is odd; with 1 it is even.
- R6: Control bit 1 selects the word length.
  - With 0, 32 bits are sent, and bit 31 is the parity bit in place of stored bit 31.
  - With 1, 25 bits are sent: stored bits 23..0, then the parity bit as bit 24.
- R7: Every bit cell lasts `2*HALF_CYC` clock cycles. The line is driven for the first `HALF_CYC` cycles and is null for the last `HALF_CYC` cycles.
- R8: After the null part of a word's last bit, the line stays null for at least `GAP_BITS` bit cells (default 4) before the next word starts.
- R9: The control word is taken from `din[1:0]` only on a rising edge of `ctl_stb`. Changes on `din` while the strobe is held high have no effect.
- R10: After reset, `tx_ready` is high, both drive bits are low, and the control word selects odd parity and 32-bit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 16 | Host data for half-word loads and for the control word |
| ld_lo | input | 1 | Load strobe for bits 15..0 of a word |
| ld_hi | input | 1 | Load strobe for bits 31..16; commits the word |
| ctl_stb | input | 1 | Control strobe; the rising edge latches `din[1:0]` |
| send_en | input | 1 | Allows words to be sent from the FIFO |
| line_hi | output | 1 | Line drive for a 1 bit |
| line_lo | output | 1 | Line drive for a 0 bit |
| tx_ready | output | 1 | FIFO can accept another word |

## Verification
- **Load timing.** A committed word raises the fill count on the clock edge that samples `ld_hi`, so `tx_ready` is sampled on the next falling edge.
- **Start of a word.** The first driven cell appears one cycle after the edge on which the idle block sees `send_en` high with data stored.
- **Bit cells.** From then on, every cell takes exactly `2*HALF_CYC` cycles. The monitor samples the line on every falling edge and measures each driven run and each null run in cycles against R7 and R8. Once the expected number of bits has arrived, it compares the word against the front of the scoreboard queue.

// File: rtl/bprz_tx.sv
module bprz_tx #(
  parameter int DW       = 16,
  parameter int DEPTH    = 8,
  parameter int HALF_CYC = 4,
  parameter int GAP_BITS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          ctl_stb,
  input  logic          send_en,
  output logic          line_hi,
  output logic          line_lo,
  output logic          tx_ready
);
  localparam int WW      = 2 * DW;
  localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW      = $clog2(DEPTH + 1);
  localparam int PW      = $clog2(2 * HALF_CYC);
  localparam int GAP_TOT = GAP_BITS * 2 * HALF_CYC;
  localparam int GW      = $clog2(GAP_TOT + 1);

  typedef enum logic [1:0] {S_IDLE, S_BITS, S_GAP} st_t;

  st_t            state;
  logic [DW-1:0]  lo_hold;
  logic [WW-1:0]  mem [DEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr;
  logic [CW-1:0]  cnt;
  logic [1:0]     ctl_q;
  logic           stb_d, wl_short;
  logic [WW-1:0]  shreg;
  logic [5:0]     bit_idx;
  logic [PW-1:0]  phase;
  logic [GW-1:0]  gap_ct;
  logic           push, pop, idle, mark, pbit, par_src;
  logic [WW-1:0]  head, frame;

  assign idle     = (state == S_IDLE);
  assign push     = ld_hi && (cnt != CW'(DEPTH));
  assign pop      = idle && send_en && (cnt != '0);
  assign tx_ready = (cnt != CW'(DEPTH));
  assign head     = mem[rd_ptr];
  assign par_src  = ctl_q[1] ? ^head[23:0] : ^head[WW-2:0];
  assign pbit     = ctl_q[0] ? par_src : ~par_src;
  assign frame    = ctl_q[1] ? {7'b0, pbit, head[23:0]} : {pbit, head[WW-2:0]};
  assign mark     = (state == S_BITS) && (phase < PW'(HALF_CYC));
  assign line_hi  = mark && shreg[0];
  assign line_lo  = mark && !shreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= 2'b00;
      stb_d <= 1'b0;
    end else begin
      stb_d <= ctl_stb;
      if (ctl_stb && !stb_d) ctl_q <= din[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (ld_lo) lo_hold <= din;
    if (push) mem[wr_ptr] <= {din, lo_hold};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      shreg    <= '0;
      bit_idx  <= '0;
      phase    <= '0;
      gap_ct   <= '0;
      wl_short <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (pop) begin
          state    <= S_BITS;
          shreg    <= frame;
          wl_short <= ctl_q[1];
          bit_idx  <= '0;
          phase    <= '0;
        end
        S_BITS: begin
          if (phase == PW'(2 * HALF_CYC - 1)) begin
            phase <= '0;
            if (bit_idx == (wl_short ? 6'd24 : 6'(WW - 1))) begin
              state  <= S_GAP;
              gap_ct <= '0;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              shreg   <= shreg >> 1;
            end
          end else begin
            phase <= phase + 1'b1;
          end
        end
        default: begin
          if (gap_ct == GW'(GAP_TOT - 1)) state <= S_IDLE;
          else gap_ct <= gap_ct + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/bprz_tx_chk.sv
module bprz_tx_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          line_hi,
  input logic          line_lo,
  input logic          ld_hi,
  input logic          ctl_stb,
  input logic          send_en,
  input logic [CW-1:0] cnt,
  input logic          pop,
  input logic          idle,
  input logic [1:0]    ctl_q
);
  // R4
  both_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_hi && line_lo));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(DEPTH) && ld_hi && !pop) |=> (cnt == CW'(DEPTH)));

  // R3
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !send_en) |=> idle);

  // R9
  ctl_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_stb && $past(ctl_stb)) |=> $stable(ctl_q));
endmodule

bind bprz_tx bprz_tx_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .line_hi(line_hi), .line_lo(line_lo),
  .ld_hi(ld_hi), .ctl_stb(ctl_stb), .send_en(send_en), .cnt(cnt),
  .pop(pop), .idle(idle), .ctl_q(ctl_q)
);

// File: tb/test_bprz_tx.sv
module test_bprz_tx;
  localparam int HALF    = 4;
  localparam int GAPB    = 4;
  localparam int GAP_TOT = GAPB * 2 * HALF;
  localparam int DEPTH   = 8;

  logic clk = 0, rst_n = 0;
  logic [15:0] din = '0;
  logic ld_lo = 0, ld_hi = 0, ctl_stb = 0, send_en = 0;
  logic line_hi, line_lo, tx_ready;

  always #4 clk = ~clk;

  bprz_tx #(.DEPTH(DEPTH), .HALF_CYC(HALF), .GAP_BITS(GAPB)) i_bprz_tx (
    .clk(clk), .rst_n(rst_n), .din(din), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .ctl_stb(ctl_stb), .send_en(send_en), .line_hi(line_hi),
    .line_lo(line_lo), .tx_ready(tx_ready));

  int n_chk = 0, n_fail = 0;
  logic [31:0] expq[$];
  bit m_even = 0, m_short = 0;
  int act_cycles = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [15:0] lo, input logic [15:0] hi);
    logic [31:0] w;
    logic p;
    w = {hi, lo};
    if (m_short) begin
      p = ^w[23:0] ^ !m_even;
      return {7'b0, p, w[23:0]};
    end
    p = ^w[30:0] ^ !m_even;
    return {p, w[30:0]};
  endfunction

  task automatic put_word(input logic [15:0] lo, input logic [15:0] hi, input bit accept);
    @(posedge clk); #1 din = lo; ld_lo = 1;
    @(posedge clk); #1 ld_lo = 0; din = hi; ld_hi = 1;
    @(posedge clk); #1 ld_hi = 0;
    if (accept) expq.push_back(model(lo, hi));
  endtask

  task automatic set_ctl(input bit even, input bit short_w);
    @(posedge clk); #1 din = {14'b0, short_w, even}; ctl_stb = 1;
    @(posedge clk); #1 ctl_stb = 0;
    m_even = even; m_short = short_w;
  endtask

  task automatic drain();
    while (expq.size() != 0) @(posedge clk);
    repeat (GAP_TOT + 2 * HALF + 4) @(posedge clk);
  endtask

  // monitor
  bit prev_act = 0, seen_word = 0, cur_bit = 0;
  int run = 0, null_run = 0, bits_got = 0;
  logic [31:0] rx = '0;
  always @(negedge clk) begin
    bit act;
    if (rst_n) begin
      act = line_hi | line_lo;
      if (line_hi && line_lo) chk(0, "R4", 3, 1);
      if (act) begin
        act_cycles++;
        if (!prev_act) begin
          if (bits_got == 0 && seen_word) chk(null_run >= GAP_TOT, "R8", null_run, GAP_TOT);
          if (bits_got > 0) chk(null_run == HALF, "R7", null_run, HALF);
          cur_bit = line_hi;
          run = 0;
        end
        run++;
      end else begin
        if (prev_act) begin
          chk(run == HALF, "R7", run, HALF);
          rx[bits_got] = cur_bit;
          bits_got++;
          if (bits_got == (m_short ? 25 : 32)) begin
            if (expq.size() == 0) chk(0, "R2", rx, 0);
            else begin
              logic [31:0] e;
              e = expq.pop_front();
              chk(rx == e, "R1/R3/R5/R6", rx, e);
            end
            bits_got = 0; rx = '0; seen_word = 1;
          end
          null_run = 0;
        end
        null_run++;
      end
      prev_act = act;
    end
  end

  initial begin
    #800000;
    chk(0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(tx_ready == 1, "R10", tx_ready, 1);
    chk(!line_hi && !line_lo, "R10", {line_hi, line_lo}, 0);

    // R10 default odd/32; R1 word assembly, R4 LSB first
    send_en = 1;
    put_word(16'h1234, 16'h8765, 1);
    put_word(16'h0000, 16'h0000, 1);
    drain();

    // R5 even parity, 32 bits
    set_ctl(1, 0);
    put_word(16'hFFFF, 16'hFFFF, 1);
    put_word(16'hA5A5, 16'h3C3C, 1);
    drain();

    // R6 25-bit words, odd then even
    set_ctl(0, 1);
    put_word(16'hBEEF, 16'hDEAD, 1);
    drain();
    set_ctl(1, 1);
    put_word(16'h0001, 16'h0080, 1);
    drain();

    // R9 held strobe ignores din changes
    @(posedge clk); #1 din = 16'h0002; ctl_stb = 1;
    @(posedge clk); #1 din = 16'h0001;
    repeat (3) @(posedge clk);
    #1 ctl_stb = 0;
    m_even = 0; m_short = 1;
    put_word(16'h5555, 16'h0F0F, 1);
    drain();
    set_ctl(0, 0);

    // R3 nothing sent while disabled; R2 fill and overflow
    send_en = 0;
    begin
      int a0;
      a0 = act_cycles;
      for (int i = 0; i < DEPTH; i++) put_word(16'(i * 16'h1111), 16'(16'hF000 - i), 1);
      @(negedge clk);
      chk(tx_ready == 0, "R2", tx_ready, 0);
      put_word(16'hDEAD, 16'hDEAD, 0);
      repeat (100) @(posedge clk);
      @(negedge clk);
      chk(act_cycles == a0, "R3", act_cycles, a0);
      chk(tx_ready == 0, "R2", tx_ready, 0);
    end
    send_en = 1;
    drain();
    @(negedge clk);
    chk(tx_ready == 1, "R2", tx_ready, 1);
    chk(expq.size() == 0 && bits_got == 0, "R2", bits_got, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule